// File: doc/BRIEF.md
# Sample-Stream Crosspoint Router with Overlay Insertion

This block is a non-blocking routing fabric for digital sample streams. There are 32 input streams and 32 output lanes, and every output lane picks one input through its own selector. Any number of lanes may pick the same input.

Each lane has a two-way overlay multiplexer after the crosspoint. When the lane's overlay control line is high, the routed sample is replaced by that lane's overlay sample. The result then passes through a gain stage that either passes the sample or doubles it. The sample is registered once and driven onto a tri-state lane port.

A global broadcast override sends one chosen input to every lane. The per-lane selectors are left untouched, so routing returns to them when broadcast ends. A lane drives its port only when three bits are all set: its own enable, the common enable and the power-on bit.

All configuration arrives as flat vectors from a separate register block. The router keeps no configuration state of its own; it only reacts to the vectors it is given.

Top module: `xpt_router`

## Requirements
- R1: While reset is high, and on the first clock edge after it, every `lane_valid` bit is 0. Lanes therefore come up disabled.
- R2: When a lane has overlay off, gain 1 and broadcast off, its output equals the input stream at index `route_sel[o*5 +: 5]`.
- R3: Several lanes may select the same input in the same cycle, and each of them receives that input's sample.
- R4: While `bcast_en` is 1, every lane's source is input `bcast_sel`, whatever its own selector holds. Once `bcast_en` returns to 0, each lane follows its own selector again.
- R5: When `ovl_ctl[o]` is 1, lane o carries `ovl_data[o*W +: W]` in place of the routed sample. This also holds during broadcast.
- R6: When `gain_x2[o]` is 1, the lane value is the sample shifted left by one bit, saturating at all-ones. With W=10, 0x1FF gives 0x3FE, and both 0x200 and 0x3FF give 0x3FF. When the bit is 0, the sample passes unchanged.
- R7: The gain stage comes after the overlay multiplexer, so an overlay sample is doubled as well.
- R8: `lane_valid[o]` is 1 exactly when `lane_en[o]`, `common_en` and `power_on` were all 1 at the previous edge. A lane whose valid flag is 0 drives 'z on its slice of `lane_out`.
- R9: Every output is registered exactly once. A change on any data, overlay or configuration input appears at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | N_IN*W | Input sample streams, stream i at bits i*W +: W |
| ovl_data | input | N_OUT*W | Per-lane overlay samples |
| ovl_ctl | input | N_OUT | Per-lane overlay select; 1 selects the overlay sample |
| route_sel | input | N_OUT*SEL_W | Per-lane input selectors |
| gain_x2 | input | N_OUT | Per-lane gain; 1 selects gain 2 |
| lane_en | input | N_OUT | Per-lane individual enables |
| common_en | input | 1 | Common output enable |
| power_on | input | 1 | Power-on bit |
| bcast_en | input | 1 | Broadcast override enable |
| bcast_sel | input | SEL_W | Input broadcast to every lane |
| lane_out | output | N_OUT*W | Tri-state lane samples |
| lane_valid | output | N_OUT | Per-lane driven flag |

## Verification
If a selector is decoded wrongly, or the broadcast override is applied badly, the affected lane shows some other stream's sample at its port one edge after the stimulus. The bench gives every input a distinct value, so any such error is visible. A gain stage placed before the overlay multiplexer, or one that wraps instead of saturating, shows up one edge later: an undoubled overlay sample appears, or a small value appears where all-ones was due. A wrong enable gate shows up as a valid flag in the wrong state after that same single edge. The scoreboard compares all 32 lanes on every cycle it drives, so none of these errors can stay hidden for more than one cycle.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Gain setting of one lane.
    typedef enum logic {
        GAIN_UNITY  = 1'b0,
        GAIN_DOUBLE = 1'b1
    } gain_e;

    // Which sample the overlay multiplexer forwards.
    typedef enum logic {
        SRC_ROUTED  = 1'b0,
        SRC_OVERLAY = 1'b1
    } lane_src_e;

    // Per-lane control flags handed to a lane slice.
    typedef struct packed {
        lane_src_e src;
        gain_e     gain;
        logic      drive;
    } lane_ctl_t;

    localparam int XPT_MAX_W = 31;

    // Double a sample of width w, clamping at the all-ones value of that width.
    function automatic logic [XPT_MAX_W-1:0] dbl_sat(input logic [XPT_MAX_W-1:0] v,
                                                     input int w);
        logic [XPT_MAX_W:0] twice;
        logic [XPT_MAX_W:0] top;
        twice = {v, 1'b0};
        top   = ({{XPT_MAX_W{1'b0}}, 1'b1} << w) - 1'b1;
        if (twice > top) begin
            return top[XPT_MAX_W-1:0];
        end
        return twice[XPT_MAX_W-1:0];
    endfunction

endpackage

// File: rtl/xpt_src_resolve.sv
module xpt_src_resolve #(
    parameter int N_OUT = 32,
    parameter int SEL_W = 5
) (
    input  logic [N_OUT*SEL_W-1:0] route_sel,
    input  logic                   bcast_en,
    input  logic [SEL_W-1:0]       bcast_sel,
    output logic [N_OUT*SEL_W-1:0] eff_sel
);
    // Broadcast overrides each lane's selector without altering it.
    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        assign eff_sel[o*SEL_W +: SEL_W] = bcast_en ? bcast_sel
                                                    : route_sel[o*SEL_W +: SEL_W];
    end
endmodule

// File: rtl/xpt_enable_gate.sv
module xpt_enable_gate #(
    parameter int N_OUT = 32
) (
    input  logic [N_OUT-1:0] lane_en,
    input  logic             common_en,
    input  logic             power_on,
    output logic [N_OUT-1:0] drive
);
    logic global_ok;
    assign global_ok = common_en & power_on;

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        assign drive[o] = lane_en[o] & global_ok;
    end
endmodule

// File: rtl/xpt_lane.sv
module xpt_lane
    import xpt_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int W     = 10,
    parameter int SEL_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_IN*W-1:0]   in_bus,
    input  logic [SEL_W-1:0]    sel,
    input  logic [W-1:0]        ovl_sample,
    input  lane_ctl_t           ctl,
    output logic [W-1:0]        sample_q,
    output logic                valid_q
);
    logic [W-1:0]           routed;
    logic [W-1:0]           chosen;
    logic [W-1:0]           scaled;
    logic [XPT_MAX_W-1:0]   wide_in;
    logic [XPT_MAX_W-1:0]   wide_dbl;

    // Crosspoint column: one of N_IN streams.
    always_comb begin
        routed = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == i[SEL_W-1:0]) begin
                routed = in_bus[i*W +: W];
            end
        end
    end

    // Overlay multiplexer ahead of the gain stage, same cycle as routing.
    assign chosen = (ctl.src == SRC_OVERLAY) ? ovl_sample : routed;

    always_comb begin
        wide_in          = '0;
        wide_in[W-1:0]   = chosen;
        wide_dbl         = dbl_sat(wide_in, W);
    end

    assign scaled = (ctl.gain == GAIN_DOUBLE) ? wide_dbl[W-1:0] : chosen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            sample_q <= scaled;
            valid_q  <= ctl.drive;
        end
    end
endmodule

// File: rtl/xpt_router.sv
module xpt_router
    import xpt_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int N_OUT = 32,
    parameter int W     = 10,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN*W-1:0]      in_data,
    input  logic [N_OUT*W-1:0]     ovl_data,
    input  logic [N_OUT-1:0]       ovl_ctl,
    input  logic [N_OUT*SEL_W-1:0] route_sel,
    input  logic [N_OUT-1:0]       gain_x2,
    input  logic [N_OUT-1:0]       lane_en,
    input  logic                   common_en,
    input  logic                   power_on,
    input  logic                   bcast_en,
    input  logic [SEL_W-1:0]       bcast_sel,
    output wire  [N_OUT*W-1:0]     lane_out,
    output logic [N_OUT-1:0]       lane_valid
);
    logic [N_OUT*SEL_W-1:0] eff_sel;
    logic [N_OUT-1:0]       drive;
    logic [N_OUT*W-1:0]     lane_q;

    xpt_src_resolve #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_resolve (
        .route_sel (route_sel),
        .bcast_en  (bcast_en),
        .bcast_sel (bcast_sel),
        .eff_sel   (eff_sel)
    );

    xpt_enable_gate #(.N_OUT(N_OUT)) u_gate (
        .lane_en   (lane_en),
        .common_en (common_en),
        .power_on  (power_on),
        .drive     (drive)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        lane_ctl_t ctl;
        assign ctl.src   = ovl_ctl[o] ? SRC_OVERLAY : SRC_ROUTED;
        assign ctl.gain  = gain_x2[o] ? GAIN_DOUBLE : GAIN_UNITY;
        assign ctl.drive = drive[o];

        xpt_lane #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .in_bus     (in_data),
            .sel        (eff_sel[o*SEL_W +: SEL_W]),
            .ovl_sample (ovl_data[o*W +: W]),
            .ctl        (ctl),
            .sample_q   (lane_q[o*W +: W]),
            .valid_q    (lane_valid[o])
        );

        assign lane_out[o*W +: W] = lane_valid[o] ? lane_q[o*W +: W] : {W{1'bz}};
    end
endmodule

// File: rtl/xpt_router_chk.sv
module xpt_router_chk #(
    parameter int N_IN  = 32,
    parameter int N_OUT = 32,
    parameter int W     = 10,
    parameter int SEL_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_IN*W-1:0]      in_data,
    input logic [N_OUT*W-1:0]     ovl_data,
    input logic [N_OUT-1:0]       ovl_ctl,
    input logic [N_OUT*SEL_W-1:0] route_sel,
    input logic [N_OUT-1:0]       gain_x2,
    input logic [N_OUT-1:0]       lane_en,
    input logic                   common_en,
    input logic                   power_on,
    input logic                   bcast_en,
    input logic [SEL_W-1:0]       bcast_sel,
    input logic [N_OUT*W-1:0]     lane_out,
    input logic [N_OUT-1:0]       lane_valid
);
    logic armed;
    logic all_same;

    always_ff @(posedge clk) begin
        armed <= !rst;
    end

    always_comb begin
        all_same = 1'b1;
        for (int o = 1; o < N_OUT; o++) begin
            if (lane_out[o*W +: W] !== lane_out[W-1:0]) begin
                all_same = 1'b0;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (lane_valid == '0));

    p_bcast_same_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(bcast_en && ovl_ctl == '0 && gain_x2 == '0) && (&lane_valid)) |-> all_same);

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        p_valid_gate_r8: assert property (@(posedge clk) disable iff (rst || !armed)
            lane_valid[o] == $past(lane_en[o] && common_en && power_on));

        p_gain_even_r6: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(gain_x2[o]) && lane_valid[o]) |->
                (lane_out[o*W] == 1'b0 || lane_out[o*W +: W] == {W{1'b1}}));

        p_overlay_pass_r5: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(ovl_ctl[o] && !gain_x2[o]) && lane_valid[o]) |->
                (lane_out[o*W +: W] == $past(ovl_data[o*W +: W])));
    end
endmodule

bind xpt_router xpt_router_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .W(W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/xpt_router_tb.sv
module xpt_router_tb;
    localparam int N_IN  = 32;
    localparam int N_OUT = 32;
    localparam int W     = 10;
    localparam int SEL_W = 5;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [N_IN*W-1:0]      in_data = '0;
    logic [N_OUT*W-1:0]     ovl_data = '0;
    logic [N_OUT-1:0]       ovl_ctl = '0;
    logic [N_OUT*SEL_W-1:0] route_sel = '0;
    logic [N_OUT-1:0]       gain_x2 = '0;
    logic [N_OUT-1:0]       lane_en = '0;
    logic                   common_en = 1'b0;
    logic                   power_on = 1'b0;
    logic                   bcast_en = 1'b0;
    logic [SEL_W-1:0]       bcast_sel = '0;
    wire  [N_OUT*W-1:0]     lane_out;
    logic [N_OUT-1:0]       lane_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    xpt_router #(.N_IN(N_IN), .N_OUT(N_OUT), .W(W), .SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .ovl_data(ovl_data),
        .ovl_ctl(ovl_ctl), .route_sel(route_sel), .gain_x2(gain_x2),
        .lane_en(lane_en), .common_en(common_en), .power_on(power_on),
        .bcast_en(bcast_en), .bcast_sel(bcast_sel),
        .lane_out(lane_out), .lane_valid(lane_valid)
    );

    typedef struct {
        logic [N_OUT*W-1:0] data;
        logic [N_OUT-1:0]   valid;
        string              tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [W-1:0] model_gain(input logic [W-1:0] v);
        if (v[W-1]) return ALL1;
        return {v[W-2:0], 1'b0};
    endfunction

    // Driver: push the expectation for the current stimulus, then let one edge pass.
    task automatic step(input string tag);
        exp_t e;
        for (int o = 0; o < N_OUT; o++) begin
            logic [SEL_W-1:0] src;
            logic [W-1:0]     s;
            src = bcast_en ? bcast_sel : route_sel[o*SEL_W +: SEL_W];
            s   = ovl_ctl[o] ? ovl_data[o*W +: W] : in_data[int'(src)*W +: W];
            if (gain_x2[o]) s = model_gain(s);
            e.data[o*W +: W] = s;
            e.valid[o]       = lane_en[o] & common_en & power_on;
        end
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: one edge after each push, compare all lanes.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                bit bad;
                e = sb.pop_front();
                checks++;
                bad = 0;
                for (int o = 0; o < N_OUT; o++) begin
                    if (!bad && lane_valid[o] !== e.valid[o]) begin
                        $display("FAIL %s lane %0d valid act=%b exp=%b", e.tag, o,
                                 lane_valid[o], e.valid[o]);
                        bad = 1;
                    end else if (!bad && e.valid[o] &&
                                 lane_out[o*W +: W] !== e.data[o*W +: W]) begin
                        $display("FAIL %s lane %0d data act=%h exp=%h", e.tag, o,
                                 lane_out[o*W +: W], e.data[o*W +: W]);
                        bad = 1;
                    end
                end
                if (bad) fails++;
            end
        end
    end

    task automatic fill_inputs(input int base);
        for (int i = 0; i < N_IN; i++) in_data[i*W +: W] = W'((i * 29 + base) % 1000 + 1);
        for (int o = 0; o < N_OUT; o++) ovl_data[o*W +: W] = W'(900 - o * 13 + base % 7);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        fill_inputs(3);
        lane_en   = '1;
        common_en = 1'b1;
        power_on  = 1'b1;
        repeat (3) @(negedge clk);
        // R1: disabled while reset is held, even with every enable set
        checks++;
        if (lane_valid !== '0) begin
            fails++;
            $display("FAIL R1 valid during reset act=%h exp=0", lane_valid);
        end
        lane_en = '0; common_en = 1'b0; power_on = 1'b0;
        rst = 1'b0;
        step("R1 first edge after reset");

        lane_en = '1; common_en = 1'b1; power_on = 1'b1;
        for (int o = 0; o < N_OUT; o++) route_sel[o*SEL_W +: SEL_W] = SEL_W'(o);
        step("R2 identity routing");
        for (int o = 0; o < N_OUT; o++) route_sel[o*SEL_W +: SEL_W] = SEL_W'(N_OUT - 1 - o);
        step("R2 reversed routing");

        for (int o = 0; o < N_OUT; o++) route_sel[o*SEL_W +: SEL_W] = (o % 2 == 0) ? 5'd5 : 5'd31;
        step("R3 shared inputs");

        // R9: data changes every cycle, each result must land after exactly one edge
        for (int k = 0; k < 4; k++) begin
            fill_inputs(100 + k * 37);
            step("R9 per-cycle data change");
        end

        for (int o = 0; o < N_OUT; o++) route_sel[o*SEL_W +: SEL_W] = SEL_W'((o * 7) % 32);
        bcast_en = 1'b1; bcast_sel = 5'd17;
        step("R4 broadcast input 17");
        bcast_sel = 5'd0;
        step("R4 broadcast input 0");
        bcast_en = 1'b0;
        step("R4 selectors restored");

        ovl_ctl = 32'hAAAA_AAAA;
        step("R5 overlay on odd lanes");
        bcast_en = 1'b1; bcast_sel = 5'd9;
        step("R5 overlay during broadcast");
        bcast_en = 1'b0; ovl_ctl = '0;

        gain_x2 = '1;
        in_data[0*W +: W] = 10'h005;
        in_data[1*W +: W] = 10'h1FF;
        in_data[2*W +: W] = 10'h200;
        in_data[3*W +: W] = 10'h3FF;
        for (int o = 0; o < N_OUT; o++) route_sel[o*SEL_W +: SEL_W] = SEL_W'(o % 4);
        step("R6 gain two with saturation");
        gain_x2 = 32'h0F0F_0F0F;
        step("R6 mixed gain lanes");

        ovl_ctl = '1; gain_x2 = '1;
        ovl_data[0*W +: W] = 10'h1FF;
        ovl_data[1*W +: W] = 10'h300;
        step("R7 overlay then gain");
        ovl_ctl = '0; gain_x2 = '0;

        common_en = 1'b0;
        step("R8 common enable off");
        common_en = 1'b1; power_on = 1'b0;
        step("R8 power bit off");
        power_on = 1'b1; lane_en = 32'h8000_0001;
        step("R8 individual enables");
        lane_en = '1;
        step("R8 all enabled again");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule